// File: doc/BRIEF.md
# Multi-Endpoint USB Packet Buffer

This block is the packet store that sits between a USB function core and the CPU of a device. It offers each side a byte-wide port. An 80-byte array holds banks for six fixed endpoints. These are a setup buffer with one bank, a control OUT endpoint and a control IN endpoint with two banks each, a first IN endpoint with two banks, an optional endpoint with two banks whose direction can be set, and a second IN endpoint with one bank. The writer of a packet is the core for OUT endpoints and the CPU for IN endpoints. The reader is the other side. A packet moves from writer to reader as a whole, and only when the writer commits it. When the reader releases the bank, the bank goes back to the writer.

Each bank has a two-state machine. BK_FILL means the writer owns the bank. BK_DRAIN means the reader owns it. The transition "commit" moves a bank from BK_FILL to BK_DRAIN and latches the byte count. The transition "release" moves it back. The transition "overwrite" also moves a bank back to BK_FILL; it applies only to the setup bank, when a new setup byte arrives while the CPU still holds that bank. The transition "clear" is caused by `cfg_clr`, or by reset, and sends every bank to BK_FILL. When the optional endpoint is switched off, its 16 bytes go to the first IN endpoint, which then has two 16-byte banks.

Top module: `usb_ep_pktbuf`

## Requirements
- R1: After reset, or in the cycle after `cfg_clr` is high, every bank is in BK_FILL. A writer selecting any enabled endpoint sees `*_rdy`=1, a reader sees `*_rdy`=0, and `ovf` and `setup_ovr` read 0.
- R2: A commit by the writer hands the current bank to the reader. The reader then sees `*_rdy`=1 and `*_cnt` equal to the number of bytes accepted. It reads the bytes in the order they were written: `*_rdata` shows the current byte, and each `*_rd` pulse moves to the next one. A reader sees `*_rdy`=0 before the commit.
- R3: A write to a bank that already holds its maximum packet size is dropped and sets the endpoint's bit in `ovf`. That bit stays set until a clear.
- R4: On endpoints 1 to 4, the writer commits into bank 0, then bank 1, then bank 0 again, and so on. The reader drains the banks in the same order. Once both banks are in BK_DRAIN, the writer sees `*_rdy`=0. Further writes are then dropped and do not set `ovf`.
- R5: A release by the reader puts its bank back into BK_FILL, and the writer sees `*_rdy`=1 for that endpoint again.
- R6: A core write to endpoint 0 while its bank is in BK_DRAIN restarts the packet, storing the byte at position 0. The bank returns to BK_FILL and `setup_ovr` is set. `setup_ovr` stays set until a clear.
- R7: When `setup_en`=0, endpoint 0 ignores all traffic, and both sides see `*_rdy`=0 for it.
- R8: When `ep2_en`=0, endpoint 3 takes 16-byte packets and endpoint 4 is disabled (`*_rdy`=0 on both sides). When `ep2_en`=1, endpoint 3 takes 8-byte packets. All other packets are at most 8 bytes.
- R9: Endpoint codes are 0 setup (core writes), 1 control OUT (core writes), 2 control IN (CPU writes), 3 first IN (CPU writes), 4 optional (CPU writes when `ep2_in`=1, core writes when `ep2_in`=0), and 5 second IN (CPU writes).
- R10: Endpoints 0 and 5 have a single bank. After one commit, the writer sees `*_rdy`=0 until the reader releases the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clr | input | 1 | Configuration change: empties all banks |
| setup_en | input | 1 | Enables the setup endpoint |
| ep2_en | input | 1 | Enables the optional endpoint 4 |
| ep2_in | input | 1 | Direction of endpoint 4 (1 = CPU writes) |
| cpu_ep | input | 3 | Endpoint selected by the CPU |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_commit | input | 1 | CPU commits the packet it has written |
| cpu_rd | input | 1 | CPU moves to the next byte it reads |
| cpu_release | input | 1 | CPU releases the bank it has read |
| cpu_rdata | output | 8 | Current byte for the CPU reader |
| cpu_rdy | output | 1 | Selected bank is available to the CPU |
| cpu_cnt | output | 5 | Packet length of the bank the CPU reads |
| core_ep | input | 3 | Endpoint selected by the core |
| core_wr | input | 1 | Core byte write strobe |
| core_wdata | input | 8 | Core write byte |
| core_commit | input | 1 | Core commits the packet it has written |
| core_rd | input | 1 | Core moves to the next byte it reads |
| core_release | input | 1 | Core releases the bank it has read |
| core_rdata | output | 8 | Current byte for the core reader |
| core_rdy | output | 1 | Selected bank is available to the core |
| core_cnt | output | 5 | Packet length of the bank the core reads |
| ovf | output | 6 | Sticky overflow flag, one bit per endpoint |
| setup_ovr | output | 1 | Sticky flag: a setup packet was overwritten |

## Verification
The assertions assume that `ep2_en` and `ep2_in` change only in the cycle when `cfg_clr` is raised. They also assume that a side never pulses write and commit for the same endpoint in the same cycle. Without the first assumption, the index bound on endpoint 3 could appear to break when its packet size shrinks. The stimulus changes the mode inputs only inside a clear task, which raises `cfg_clr` in that same cycle. Each write, commit, read and release is issued as its own one-cycle pulse, with all strobes low in between.

// File: rtl/upb_pkg.sv
package upb_pkg;
    localparam int NEP    = 6;
    localparam int BANK_B = 8;
    localparam int WIDE_B = 2 * BANK_B;
    localparam int DEPTH  = 10 * BANK_B;
    localparam int AW     = $clog2(DEPTH);
    localparam int IW     = $clog2(WIDE_B) + 1;
    localparam int EPW    = $clog2(NEP);

    typedef enum logic {BK_FILL, BK_DRAIN} bank_st_e;

    // byte offset of each endpoint region; endpoint 3 grows into endpoint 4 space
    function automatic logic [AW-1:0] ep_base(int e);
        case (e)
            0:       return AW'(0);
            1:       return AW'(BANK_B);
            2:       return AW'(3 * BANK_B);
            3:       return AW'(5 * BANK_B);
            4:       return AW'(7 * BANK_B);
            default: return AW'(9 * BANK_B);
        endcase
    endfunction

    function automatic logic [IW-1:0] ep_bsz(int e, logic wide);
        return (e == 3 && wide) ? IW'(WIDE_B) : IW'(BANK_B);
    endfunction
endpackage

// File: rtl/upb_store.sv
module upb_store
    import upb_pkg::*;
(
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [7:0]    wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [7:0]    wd_b,
    input  logic [AW-1:0] ra_a,
    output logic [7:0]    rq_a,
    input  logic [AW-1:0] ra_b,
    output logic [7:0]    rq_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a && wa_a < AW'(DEPTH)) mem[wa_a] <= wd_a;
        if (we_b && wa_b < AW'(DEPTH)) mem[wa_b] <= wd_b;
    end

    always_comb begin
        rq_a = (ra_a < AW'(DEPTH)) ? mem[ra_a] : 8'h00;
        rq_b = (ra_b < AW'(DEPTH)) ? mem[ra_b] : 8'h00;
    end
endmodule

// File: rtl/upb_ep_ctl.sv
module upb_ep_ctl
    import upb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          en,
    input  logic          dbl,
    input  logic          ovw_en,
    input  logic [IW-1:0] max_len,
    input  logic          wr,
    input  logic          commit,
    input  logic          rd,
    input  logic          rel,
    output logic          w_ok,
    output logic [IW-1:0] w_idx,
    output logic          w_bank,
    output logic          w_free,
    output logic          r_full,
    output logic          r_bank,
    output logic [IW-1:0] r_idx,
    output logic [IW-1:0] r_cnt,
    output logic          ovf,
    output logic          overrun
);
    bank_st_e      st_q [2];
    bank_st_e      st_d [2];
    logic [IW-1:0] cnt_q [2];
    logic [IW-1:0] widx_q, ridx_q;
    logic          wb_q, rb_q, ovf_q, ovr_q;
    logic          ovw, over, commit_ok, rel_ok, rd_ok;

    always_comb begin
        w_free    = en && (st_q[wb_q] == BK_FILL);
        r_full    = en && (st_q[rb_q] == BK_DRAIN);
        ovw       = en && ovw_en && wr && (st_q[0] == BK_DRAIN);
        w_ok      = (wr && w_free && (widx_q < max_len)) || ovw;
        over      = wr && w_free && (widx_q >= max_len);
        commit_ok = commit && w_free;
        rel_ok    = rel && r_full;
        rd_ok     = rd && r_full && (ridx_q < cnt_q[rb_q]);
    end

    // next state of each bank
    always_comb begin
        for (int b = 0; b < 2; b++) begin
            st_d[b] = st_q[b];
            unique case (st_q[b])
                BK_FILL:  if (commit_ok && wb_q == 1'(b)) st_d[b] = BK_DRAIN;
                BK_DRAIN: if ((rel_ok && rb_q == 1'(b)) || (ovw && b == 0)) st_d[b] = BK_FILL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) st_q[b] <= BK_FILL;
        end else if (flush) begin
            for (int b = 0; b < 2; b++) st_q[b] <= BK_FILL;
        end else begin
            for (int b = 0; b < 2; b++) st_q[b] <= st_d[b];
        end
    end

    // pointers, counts and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) cnt_q[b] <= '0;
            widx_q <= '0; ridx_q <= '0; wb_q <= 1'b0; rb_q <= 1'b0;
            ovf_q  <= 1'b0; ovr_q <= 1'b0;
        end else if (flush) begin
            for (int b = 0; b < 2; b++) cnt_q[b] <= '0;
            widx_q <= '0; ridx_q <= '0; wb_q <= 1'b0; rb_q <= 1'b0;
            ovf_q  <= 1'b0; ovr_q <= 1'b0;
        end else begin
            if (commit_ok) begin
                cnt_q[wb_q] <= widx_q;
                widx_q      <= '0;
                wb_q        <= dbl ? ~wb_q : 1'b0;
            end else if (ovw) begin
                widx_q <= IW'(1);
            end else if (w_ok) begin
                widx_q <= widx_q + IW'(1);
            end
            if (ovw) begin
                ridx_q <= '0;
            end else if (rel_ok) begin
                ridx_q <= '0;
                rb_q   <= dbl ? ~rb_q : 1'b0;
            end else if (rd_ok) begin
                ridx_q <= ridx_q + IW'(1);
            end
            if (over) ovf_q <= 1'b1;
            if (ovw)  ovr_q <= 1'b1;
        end
    end

    always_comb begin
        w_idx   = ovw ? '0 : widx_q;
        w_bank  = wb_q;
        r_bank  = rb_q;
        r_idx   = ridx_q;
        r_cnt   = cnt_q[rb_q];
        ovf     = ovf_q;
        overrun = ovr_q;
    end

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (widx_q == '0 && ridx_q == '0 && !ovf_q && !ovr_q));
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n || flush)
        widx_q <= max_len);
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n || flush)
        ovf_q |=> ovf_q);
    a_r2_read_in_packet: assert property (@(posedge clk) disable iff (!rst_n || flush)
        r_full |-> ridx_q <= cnt_q[rb_q]);
    a_r4_bank_alternates: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (commit_ok && dbl) |=> wb_q != $past(wb_q));
    a_r10_single_release: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (rel_ok && !dbl) |=> (w_free && !r_full));
    a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n || flush)
        ovw |=> ovr_q);
endmodule

// File: rtl/usb_ep_pktbuf.sv
module usb_ep_pktbuf
    import upb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_clr,
    input  logic           setup_en,
    input  logic           ep2_en,
    input  logic           ep2_in,
    input  logic [EPW-1:0] cpu_ep,
    input  logic           cpu_wr,
    input  logic [7:0]     cpu_wdata,
    input  logic           cpu_commit,
    input  logic           cpu_rd,
    input  logic           cpu_release,
    output logic [7:0]     cpu_rdata,
    output logic           cpu_rdy,
    output logic [IW-1:0]  cpu_cnt,
    input  logic [EPW-1:0] core_ep,
    input  logic           core_wr,
    input  logic [7:0]     core_wdata,
    input  logic           core_commit,
    input  logic           core_rd,
    input  logic           core_release,
    output logic [7:0]     core_rdata,
    output logic           core_rdy,
    output logic [IW-1:0]  core_cnt,
    output logic [NEP-1:0] ovf,
    output logic           setup_ovr
);
    logic [NEP-1:0] dir_in, en, wr_e, cm_e, rd_e, rl_e;
    logic [NEP-1:0] w_ok, w_free, r_full, wb, rb, ovf_e, ovr_e;
    logic [IW-1:0]  widx [NEP];
    logic [IW-1:0]  ridx [NEP];
    logic [IW-1:0]  rcnt [NEP];
    logic [IW-1:0]  bsz  [NEP];
    logic [AW-1:0]  waddr [NEP];
    logic [AW-1:0]  raddr [NEP];

    for (genvar e = 0; e < NEP; e++) begin : g_ep
        localparam bit DBL = (e >= 1 && e <= 4);
        assign dir_in[e] = (e == 4) ? ep2_in : (e == 2 || e == 3 || e == 5);
        assign en[e]     = (e == 0) ? setup_en : (e == 4) ? ep2_en : 1'b1;
        assign bsz[e]    = ep_bsz(e, !ep2_en);
        assign wr_e[e]   = dir_in[e] ? (cpu_wr && cpu_ep == EPW'(e)) : (core_wr && core_ep == EPW'(e));
        assign cm_e[e]   = dir_in[e] ? (cpu_commit && cpu_ep == EPW'(e)) : (core_commit && core_ep == EPW'(e));
        assign rd_e[e]   = dir_in[e] ? (core_rd && core_ep == EPW'(e)) : (cpu_rd && cpu_ep == EPW'(e));
        assign rl_e[e]   = dir_in[e] ? (core_release && core_ep == EPW'(e)) : (cpu_release && cpu_ep == EPW'(e));
        assign waddr[e]  = ep_base(e) + (wb[e] ? AW'(bsz[e]) : {AW{1'b0}}) + AW'(widx[e]);
        assign raddr[e]  = ep_base(e) + (rb[e] ? AW'(bsz[e]) : {AW{1'b0}}) + AW'(ridx[e]);

        upb_ep_ctl u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (cfg_clr),
            .en      (en[e]),
            .dbl     (DBL),
            .ovw_en  (e == 0),
            .max_len (bsz[e]),
            .wr      (wr_e[e]),
            .commit  (cm_e[e]),
            .rd      (rd_e[e]),
            .rel     (rl_e[e]),
            .w_ok    (w_ok[e]),
            .w_idx   (widx[e]),
            .w_bank  (wb[e]),
            .w_free  (w_free[e]),
            .r_full  (r_full[e]),
            .r_bank  (rb[e]),
            .r_idx   (ridx[e]),
            .r_cnt   (rcnt[e]),
            .ovf     (ovf_e[e]),
            .overrun (ovr_e[e])
        );
    end

    logic          cpu_we, core_we;
    logic [AW-1:0] cpu_wa, core_wa, cpu_ra, core_ra;

    always_comb begin
        cpu_we = 1'b0; cpu_wa = '0; cpu_ra = '0; cpu_rdy = 1'b0; cpu_cnt = '0;
        core_we = 1'b0; core_wa = '0; core_ra = '0; core_rdy = 1'b0; core_cnt = '0;
        for (int e = 0; e < NEP; e++) begin
            if (cpu_ep == EPW'(e)) begin
                if (dir_in[e]) begin
                    cpu_we = w_ok[e]; cpu_wa = waddr[e]; cpu_rdy = w_free[e];
                end else begin
                    cpu_ra = raddr[e]; cpu_rdy = r_full[e];
                    cpu_cnt = r_full[e] ? rcnt[e] : '0;
                end
            end
            if (core_ep == EPW'(e)) begin
                if (!dir_in[e]) begin
                    core_we = w_ok[e]; core_wa = waddr[e]; core_rdy = w_free[e];
                end else begin
                    core_ra = raddr[e]; core_rdy = r_full[e];
                    core_cnt = r_full[e] ? rcnt[e] : '0;
                end
            end
        end
    end

    upb_store u_store (
        .clk  (clk),
        .we_a (cpu_we),
        .wa_a (cpu_wa),
        .wd_a (cpu_wdata),
        .we_b (core_we),
        .wa_b (core_wa),
        .wd_b (core_wdata),
        .ra_a (cpu_ra),
        .rq_a (cpu_rdata),
        .ra_b (core_ra),
        .rq_b (core_rdata)
    );

    assign ovf       = ovf_e;
    assign setup_ovr = ovr_e[0];

    a_r8_ep4_off_idle: assert property (@(posedge clk) disable iff (!rst_n || cfg_clr)
        !ep2_en |-> (!w_free[4] && !r_full[4]));
    a_r7_setup_off_idle: assert property (@(posedge clk) disable iff (!rst_n || cfg_clr)
        !setup_en |-> !w_ok[0]);
    a_r9_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && core_we && cpu_wa == core_wa));
endmodule

// File: tb/tb_usb_ep_pktbuf.sv
module tb_usb_ep_pktbuf;
    import upb_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, cfg_clr = 1'b0;
    logic setup_en = 1'b1, ep2_en = 1'b1, ep2_in = 1'b1;
    logic [EPW-1:0] cpu_ep = '0, core_ep = '0;
    logic cpu_wr = 0, cpu_commit = 0, cpu_rd = 0, cpu_release = 0;
    logic core_wr = 0, core_commit = 0, core_rd = 0, core_release = 0;
    logic [7:0] cpu_wdata = '0, core_wdata = '0, cpu_rdata, core_rdata;
    logic cpu_rdy, core_rdy, setup_ovr;
    logic [IW-1:0] cpu_cnt, core_cnt;
    logic [NEP-1:0] ovf;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    usb_ep_pktbuf dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sel(int c, int k);
        @(negedge clk);
        cpu_ep = EPW'(c); core_ep = EPW'(k);
        #1;
    endtask

    // driver: writes n bytes, pushes the first keep into the scoreboard
    task automatic wr_pkt(bit cpu, int ep, int n, int keep, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu) begin cpu_ep = EPW'(ep); cpu_wdata = 8'(seed + i); cpu_wr = 1; end
            else     begin core_ep = EPW'(ep); core_wdata = 8'(seed + i); core_wr = 1; end
            if (i < keep) exp_q.push_back(8'(seed + i));
            @(negedge clk);
            cpu_wr = 0; core_wr = 0;
        end
    endtask

    task automatic pulse(bit cpu, int ep, bit is_commit);
        @(negedge clk);
        if (cpu) begin
            cpu_ep = EPW'(ep);
            if (is_commit) cpu_commit = 1; else cpu_release = 1;
        end else begin
            core_ep = EPW'(ep);
            if (is_commit) core_commit = 1; else core_release = 1;
        end
        @(negedge clk);
        cpu_commit = 0; cpu_release = 0; core_commit = 0; core_release = 0;
        #1;
    endtask

    // monitor: pops expected bytes and compares them with the reader port
    task automatic rd_pkt(bit cpu, int ep, int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu) cpu_ep = EPW'(ep); else core_ep = EPW'(ep);
            #1;
            if (exp_q.size() == 0) begin
                chk({req, " scoreboard empty"}, 1, 0);
            end else begin
                chk({req, " data"}, cpu ? int'(cpu_rdata) : int'(core_rdata), int'(exp_q.pop_front()));
            end
            if (cpu) cpu_rd = 1; else core_rd = 1;
            @(negedge clk);
            cpu_rd = 0; core_rd = 0;
        end
    endtask

    task automatic clear(bit s, bit e2, bit e2i);
        @(negedge clk);
        setup_en = s; ep2_en = e2; ep2_in = e2i; cfg_clr = 1;
        @(negedge clk);
        cfg_clr = 0;
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        sel(2, 2);
        chk("R1 cpu writer rdy", cpu_rdy, 1);
        chk("R1 core reader rdy", core_rdy, 0);
        chk("R1 ovf", ovf, 0);
        // R2 IN packet on control IN
        wr_pkt(1, 2, 5, 5, 8'h30);
        sel(2, 2);
        chk("R2 reader before commit", core_rdy, 0);
        pulse(1, 2, 1);
        sel(2, 2);
        chk("R2 core rdy", core_rdy, 1);
        chk("R2 core cnt", core_cnt, 5);
        rd_pkt(0, 2, 5, "R2");
        pulse(0, 2, 0);
        sel(2, 2);
        chk("R5 bank back", core_rdy, 0);
        // R4 ping-pong on endpoint 3
        wr_pkt(1, 3, 3, 3, 8'h50);
        pulse(1, 3, 1);
        sel(3, 3);
        chk("R4 second bank free", cpu_rdy, 1);
        wr_pkt(1, 3, 4, 4, 8'h60);
        pulse(1, 3, 1);
        sel(3, 3);
        chk("R4 both full", cpu_rdy, 0);
        wr_pkt(1, 3, 1, 0, 8'hEE);
        chk("R4 drop no ovf", ovf[3], 0);
        chk("R4 first cnt", core_cnt, 3);
        rd_pkt(0, 3, 3, "R4 bank0");
        pulse(0, 3, 0);
        sel(3, 3);
        chk("R5 writer rdy", cpu_rdy, 1);
        chk("R4 second cnt", core_cnt, 4);
        rd_pkt(0, 3, 4, "R4 bank1");
        pulse(0, 3, 0);
        // R3 overflow and R10 single bank on endpoint 5
        wr_pkt(1, 5, 10, 8, 8'h70);
        chk("R3 ovf set", ovf[5], 1);
        pulse(1, 5, 1);
        sel(5, 5);
        chk("R10 single full", cpu_rdy, 0);
        chk("R3 cnt capped", core_cnt, 8);
        rd_pkt(0, 5, 8, "R3");
        pulse(0, 5, 0);
        sel(5, 5);
        chk("R10 released", cpu_rdy, 1);
        chk("R3 sticky", ovf[5], 1);
        // R9 OUT on control OUT
        wr_pkt(0, 1, 6, 6, 8'h90);
        sel(1, 1);
        chk("R9 cpu not yet", cpu_rdy, 0);
        pulse(0, 1, 1);
        sel(1, 1);
        chk("R9 cpu rdy", cpu_rdy, 1);
        chk("R9 cpu cnt", cpu_cnt, 6);
        rd_pkt(1, 1, 6, "R9");
        pulse(1, 1, 0);
        // R6 setup overwrite
        wr_pkt(0, 0, 8, 0, 8'h10);
        pulse(0, 0, 1);
        sel(0, 0);
        chk("R6 ovr before", setup_ovr, 0);
        wr_pkt(0, 0, 3, 3, 8'hA0);
        chk("R6 ovr set", setup_ovr, 1);
        pulse(0, 0, 1);
        sel(0, 0);
        chk("R6 new cnt", cpu_cnt, 3);
        rd_pkt(1, 0, 3, "R6");
        pulse(1, 0, 0);
        // R1 clear
        clear(1, 1, 1);
        sel(5, 5);
        chk("R1 clr ovf", ovf, 0);
        chk("R1 clr ovr", setup_ovr, 0);
        chk("R1 clr writer rdy", cpu_rdy, 1);
        // R7 setup disabled
        clear(0, 1, 1);
        wr_pkt(0, 0, 2, 0, 8'h11);
        pulse(0, 0, 1);
        sel(0, 0);
        chk("R7 cpu rdy", cpu_rdy, 0);
        chk("R7 core rdy", core_rdy, 0);
        // R8 wide endpoint 3, endpoint 4 off
        clear(1, 0, 1);
        wr_pkt(1, 3, 16, 16, 8'hC0);
        chk("R8 16 no ovf", ovf[3], 0);
        pulse(1, 3, 1);
        sel(4, 3);
        chk("R8 wide cnt", core_cnt, 16);
        chk("R8 ep4 off", cpu_rdy, 0);
        rd_pkt(0, 3, 16, "R8");
        // R9 endpoint 4 as OUT, R8 narrow endpoint 3
        clear(1, 1, 0);
        sel(4, 4);
        chk("R9 ep4 cpu reader", cpu_rdy, 0);
        chk("R9 ep4 core writer", core_rdy, 1);
        wr_pkt(0, 4, 4, 4, 8'hD0);
        pulse(0, 4, 1);
        sel(4, 4);
        chk("R9 ep4 cnt", cpu_cnt, 4);
        rd_pkt(1, 4, 4, "R9 ep4");
        wr_pkt(1, 3, 9, 0, 8'h01);
        chk("R8 narrow ovf", ovf[3], 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule